// File: doc/BRIEF.md
# Dual Record/Playback Byte FIFO

This block holds two byte-wide first-in first-out buffers that sit between a host bus and a voice codec. One buffer carries host data toward the decoder (playback). The other carries captured samples from the encoder back to the host (record). Each buffer has two ports. The playback buffer is written by the host and read by the decoder. The record buffer is written by the encoder and read by the host.

A configuration input selects one of three run-time capacities, and the same capacity applies to both buffers. Each buffer derives empty, more-than-half and full indications from a registered occupancy count. A select input routes one buffer's flags onto a shared set of flag outputs. A polarity bit can turn the empty and full outputs active-low.

A sticky start output tells the decoder it may begin. It goes high only after the playback buffer has first held data. Changing the capacity code empties both buffers and withdraws the start indication.

Top module: `dual_rp_fifo`

## Requirements
- R1: After reset both buffers are empty and the capacity is the largest one. With polarity bit 0, `flag_empty` is 1, `flag_half` and `flag_full` are 0, and `dec_go` is 0.
- R2: `cfg_depth` selects the capacity of both buffers. Code 2'b00 gives MAX_DEPTH, 2'b01 gives MAX_DEPTH/2, 2'b10 gives MAX_DEPTH/4, and 2'b11 gives MAX_DEPTH. The full flag asserts when the occupancy equals the selected capacity.
- R3: The half flag is 1 exactly when the occupancy is strictly greater than half the selected capacity.
- R4: Bytes leave each buffer in the order they entered. The read data port always shows the oldest stored byte, before the read strobe is given.
- R5: With `cfg_flag_lo` = 1, `flag_empty` and `flag_full` are inverted, so a 0 means active. `flag_half` is always active-high.
- R6: An encoder write (`i_wr`) to a full record buffer is discarded.
- R7: A host write (`h_wr`) to a full playback buffer is discarded.
- R8: With `flag_sel` = 0 the shared flags describe the playback buffer. With `flag_sel` = 1 they describe the record buffer.
- R9: A clock edge at which `cfg_depth` differs from the capacity code in use does three things: it adopts the new code, empties both buffers, and clears `dec_go`. Reads and writes presented at that edge are discarded.
- R10: `dec_go` rises one cycle after the playback buffer first holds data. It stays high until reset or a capacity change, even when the buffer drains.
- R11: A write and a read at the same edge on a buffer that is neither empty nor full leave its occupancy unchanged. A read of an empty buffer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Capacity code (R2) |
| cfg_flag_lo | input | 1 | 1 = empty/full outputs active-low |
| flag_sel | input | 1 | 0 = playback flags, 1 = record flags |
| h_wr | input | 1 | Host write strobe into playback buffer |
| h_wdata | input | DATA_W | Host write data |
| h_rd | input | 1 | Host read strobe from record buffer |
| h_rdata | output | DATA_W | Oldest record byte |
| i_wr | input | 1 | Encoder write strobe into record buffer |
| i_wdata | input | DATA_W | Encoder write data |
| i_rd | input | 1 | Decoder read strobe from playback buffer |
| i_rdata | output | DATA_W | Oldest playback byte |
| flag_empty | output | 1 | Selected buffer empty (polarity per cfg_flag_lo) |
| flag_half | output | 1 | Selected buffer more than half full |
| flag_full | output | 1 | Selected buffer full (polarity per cfg_flag_lo) |
| dec_go | output | 1 | Decoder may start (sticky) |

## Verification
The bench builds the block with its defaults, MAX_DEPTH = 128 and DATA_W = 8, so all three capacities (128, 64 and 32 words) are in use. Each capacity's full boundary and half boundary is exercised at least once, and the 64-word and 32-word cases include overflow attempts. Running at the 32-word capacity keeps long sequences short, such as the simultaneous read-and-write run and the record overflow. The 128-word case covers the pointer width at its widest.

// File: rtl/dual_rp_fifo_pkg.sv
package dual_rp_fifo_pkg;
   typedef enum logic [1:0] {
      DEPTH_FULL    = 2'b00,
      DEPTH_HALF    = 2'b01,
      DEPTH_QUARTER = 2'b10,
      DEPTH_ALT     = 2'b11
   } depth_code_e;

   localparam int unsigned N_FIFO = 2;
   localparam int unsigned IDX_PB  = 0;
   localparam int unsigned IDX_REC = 1;

   function automatic int unsigned depth_of(input logic [1:0] code, input int unsigned max_d);
      case (code)
         2'b01:   return max_d / 2;
         2'b10:   return max_d / 4;
         default: return max_d;
      endcase
   endfunction
endpackage

// File: rtl/rp_byte_fifo.sv
module rp_byte_fifo #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MAX_DEPTH = 128,
   localparam int unsigned AW = $clog2(MAX_DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [CW-1:0]     depth,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata,
   output logic [CW-1:0]     cnt
);
   logic [DATA_W-1:0] mem [MAX_DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic              wr_ok, rd_ok;
   logic [AW-1:0]     last;

   assign last  = AW'(depth - 1'b1);
   assign wr_ok = wr && !clr && (cnt != depth);
   assign rd_ok = rd && !clr && (cnt != '0);
   assign rdata = mem[rptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_ok) wptr <= (wptr == last) ? '0 : wptr + 1'b1;
         if (rd_ok) rptr <= (rptr == last) ? '0 : rptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/rp_flag_gen.sv
module rp_flag_gen #(
   parameter int unsigned CW = 8
) (
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] depth,
   output logic          empty,
   output logic          half,
   output logic          full
);
   assign empty = (cnt == '0);
   assign full  = (cnt == depth);
   assign half  = (cnt > (depth >> 1));
endmodule

// File: rtl/dual_rp_fifo.sv
module dual_rp_fifo
   import dual_rp_fifo_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MAX_DEPTH = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_depth,
   input  logic              cfg_flag_lo,
   input  logic              flag_sel,
   input  logic              h_wr,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_rd,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              i_wr,
   input  logic [DATA_W-1:0] i_wdata,
   input  logic              i_rd,
   output logic [DATA_W-1:0] i_rdata,
   output logic              flag_empty,
   output logic              flag_half,
   output logic              flag_full,
   output logic              dec_go
);
   localparam int unsigned AW = $clog2(MAX_DEPTH);
   localparam int unsigned CW = AW + 1;

   if ((1 << AW) != MAX_DEPTH || MAX_DEPTH < 8) begin : g_bad_depth
      $error("MAX_DEPTH must be a power of two of at least 8");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [1:0]        depth_q;
   logic              clr;
   logic [CW-1:0]     depth_words;
   logic [CW-1:0]     cnt  [N_FIFO];
   logic              we   [N_FIFO];
   logic              re   [N_FIFO];
   logic [DATA_W-1:0] wd   [N_FIFO];
   logic [DATA_W-1:0] rdt  [N_FIFO];
   logic              f_e  [N_FIFO];
   logic              f_h  [N_FIFO];
   logic              f_f  [N_FIFO];
   logic              go_q;

   assign clr         = (cfg_depth != depth_q);
   assign depth_words = CW'(depth_of(depth_q, MAX_DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) depth_q <= DEPTH_FULL;
      else        depth_q <= cfg_depth;
   end

   assign we[IDX_PB]  = h_wr;
   assign wd[IDX_PB]  = h_wdata;
   assign re[IDX_PB]  = i_rd;
   assign we[IDX_REC] = i_wr;
   assign wd[IDX_REC] = i_wdata;
   assign re[IDX_REC] = h_rd;
   assign i_rdata     = rdt[IDX_PB];
   assign h_rdata     = rdt[IDX_REC];

   for (genvar g = 0; g < N_FIFO; g++) begin : g_fifo
      rp_byte_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .depth (depth_words),
         .wr    (we[g]),
         .wdata (wd[g]),
         .rd    (re[g]),
         .rdata (rdt[g]),
         .cnt   (cnt[g])
      );
      rp_flag_gen #(.CW(CW)) u_flags (
         .cnt   (cnt[g]),
         .depth (depth_words),
         .empty (f_e[g]),
         .half  (f_h[g]),
         .full  (f_f[g])
      );
   end

   always_comb begin
      logic e, h, f;
      if (flag_sel) begin
         e = f_e[IDX_REC]; h = f_h[IDX_REC]; f = f_f[IDX_REC];
      end else begin
         e = f_e[IDX_PB];  h = f_h[IDX_PB];  f = f_f[IDX_PB];
      end
      flag_empty = e ^ cfg_flag_lo;
      flag_full  = f ^ cfg_flag_lo;
      flag_half  = h;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   go_q <= 1'b0;
      else if (clr) go_q <= 1'b0;
      else          go_q <= go_q | !f_e[IDX_PB];
   end
   assign dec_go = go_q;
endmodule

// File: rtl/dual_rp_fifo_chk.sv
module dual_rp_fifo_chk #(
   parameter int unsigned CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic [CW-1:0] depth_words,
   input logic [CW-1:0] pb_cnt,
   input logic [CW-1:0] rec_cnt,
   input logic          h_wr,
   input logic          h_rd,
   input logic          i_wr,
   input logic          i_rd,
   input logic          dec_go
);
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_cnt <= depth_words) && (rec_cnt <= depth_words));

   a_r6_rec_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_cnt == depth_words && i_wr && !h_rd && !clr) |=> (rec_cnt == $past(rec_cnt)));

   a_r7_pb_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_cnt == depth_words && h_wr && !i_rd && !clr) |=> (pb_cnt == $past(pb_cnt)));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pb_cnt == '0 && rec_cnt == '0 && !dec_go));

   a_r10_go_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_go) |-> ($past(pb_cnt) != '0));

   a_r11_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && i_rd && pb_cnt != '0 && pb_cnt != depth_words && !clr) |=> $stable(pb_cnt));
endmodule

bind dual_rp_fifo dual_rp_fifo_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr         (clr),
   .depth_words (depth_words),
   .pb_cnt      (cnt[0]),
   .rec_cnt     (cnt[1]),
   .h_wr        (h_wr),
   .h_rd        (h_rd),
   .i_wr        (i_wr),
   .i_rd        (i_rd),
   .dec_go      (dec_go)
);

// File: tb/dual_rp_fifo_bench.sv
module dual_rp_fifo_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_depth = 2'b00;
   logic       cfg_flag_lo = 1'b0;
   logic       flag_sel = 1'b0;
   logic       h_wr = 1'b0, h_rd = 1'b0, i_wr = 1'b0, i_rd = 1'b0;
   logic [7:0] h_wdata = '0, i_wdata = '0;
   logic [7:0] h_rdata, i_rdata;
   logic       flag_empty, flag_half, flag_full, dec_go;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   dual_rp_fifo u_dual_rp_fifo (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_flag_lo(cfg_flag_lo),
      .flag_sel(flag_sel), .h_wr(h_wr), .h_wdata(h_wdata), .h_rd(h_rd),
      .h_rdata(h_rdata), .i_wr(i_wr), .i_wdata(i_wdata), .i_rd(i_rd),
      .i_rdata(i_rdata), .flag_empty(flag_empty), .flag_half(flag_half),
      .flag_full(flag_full), .dec_go(dec_go)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic flags(input string req, input logic e, input logic h, input logic f);
      chk({req, " empty"}, flag_empty, e);
      chk({req, " half"},  flag_half,  h);
      chk({req, " full"},  flag_full,  f);
   endtask

   task automatic pb_push(input logic [7:0] d);
      h_wr = 1'b1; h_wdata = d;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic rec_push(input logic [7:0] d);
      i_wr = 1'b1; i_wdata = d;
      @(negedge clk);
      i_wr = 1'b0;
   endtask

   task automatic pb_pop(input string req, input logic [7:0] exp);
      chk(req, i_rdata, exp);
      i_rd = 1'b1;
      @(negedge clk);
      i_rd = 1'b0;
   endtask

   task automatic rec_pop(input string req, input logic [7:0] exp);
      chk(req, h_rdata, exp);
      h_rd = 1'b1;
      @(negedge clk);
      h_rd = 1'b0;
   endtask

   task automatic set_depth(input logic [1:0] c);
      cfg_depth = c;
      @(negedge clk);
   endtask

   task automatic t_reset;
      flags("R1 reset", 1'b1, 1'b0, 1'b0);
      chk("R1 reset dec_go", dec_go, 1'b0);
      flag_sel = 1'b1;
      #1 flags("R1 reset rec", 1'b1, 1'b0, 1'b0);
      flag_sel = 1'b0;
   endtask

   task automatic t_pb_depth64;
      set_depth(2'b01);
      for (int i = 0; i < 32; i++) pb_push(8'(i * 3 + 1));
      flags("R3 pb at 32/64", 1'b0, 1'b0, 1'b0);
      chk("R10 dec_go after data", dec_go, 1'b1);
      pb_push(8'(32 * 3 + 1));
      flags("R3 pb at 33/64", 1'b0, 1'b1, 1'b0);
      for (int i = 33; i < 64; i++) pb_push(8'(i * 3 + 1));
      flags("R2 pb full at 64", 1'b0, 1'b1, 1'b1);
      pb_push(8'hEE);
      flags("R7 pb still full", 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 64; i++) pb_pop("R4 R7 pb order", 8'(i * 3 + 1));
      flags("R7 pb empty after 64 reads", 1'b1, 1'b0, 1'b0);
      chk("R10 dec_go held after drain", dec_go, 1'b1);
   endtask

   task automatic t_rec_depth32;
      flag_sel = 1'b1;
      set_depth(2'b10);
      chk("R9 dec_go cleared", dec_go, 1'b0);
      h_rd = 1'b1;
      @(negedge clk);
      h_rd = 1'b0;
      flags("R11 read of empty ignored", 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 40; i++) rec_push(8'(8'h80 + i));
      flags("R2 R6 rec full at 32", 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 32; i++) rec_pop("R6 rec keeps first 32", 8'(8'h80 + i));
      flags("R6 rec empty", 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_polarity_select;
      for (int i = 0; i < 32; i++) rec_push(8'(i));
      cfg_flag_lo = 1'b1;
      #1 flags("R5 active-low rec full", 1'b1, 1'b1, 1'b0);
      flag_sel = 1'b0;
      #1 flags("R5 R8 active-low pb empty", 1'b0, 1'b0, 1'b1);
      cfg_flag_lo = 1'b0;
      #1 flags("R8 pb selected while rec full", 1'b1, 1'b0, 1'b0);
      flag_sel = 1'b1;
      #1 flags("R8 rec selected", 1'b0, 1'b1, 1'b1);
      flag_sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_balanced;
      for (int i = 0; i < 16; i++) pb_push(8'(8'h40 + i));
      for (int i = 0; i < 8; i++) begin
         chk("R11 read data during balanced run", i_rdata, 8'(8'h40 + i));
         h_wr = 1'b1; h_wdata = 8'(8'h50 + i); i_rd = 1'b1;
         @(negedge clk);
         h_wr = 1'b0; i_rd = 1'b0;
      end
      flags("R11 count held at 16/32", 1'b0, 1'b0, 1'b0);
      pb_push(8'hAA);
      flags("R11 R3 count now 17/32", 1'b0, 1'b1, 1'b0);
      for (int i = 8; i < 16; i++) pb_pop("R4 balanced tail", 8'(8'h40 + i));
      pb_pop("R4 balanced new", 8'h50);
   endtask

   task automatic t_depth_clear;
      cfg_depth = 2'b00;
      h_wr = 1'b1; h_wdata = 8'h11;
      @(negedge clk);
      h_wr = 1'b0;
      flags("R9 pb cleared", 1'b1, 1'b0, 1'b0);
      chk("R9 dec_go cleared on change", dec_go, 1'b0);
      flag_sel = 1'b1;
      #1 flags("R9 rec cleared", 1'b1, 1'b0, 1'b0);
      flag_sel = 1'b0;
      for (int i = 0; i < 64; i++) pb_push(8'(i));
      flags("R3 pb at 64/128", 1'b0, 1'b0, 1'b0);
      for (int i = 64; i < 128; i++) pb_push(8'(i));
      flags("R2 pb full at 128", 1'b0, 1'b1, 1'b1);
      pb_pop("R4 depth128 head", 8'h00);
      set_depth(2'b11);
      flags("R2 R9 code 11 change clears", 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 128; i++) pb_push(8'(i));
      flags("R2 code 11 full at 128", 1'b0, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pb_depth64();
      t_rec_depth32();
      t_polarity_select();
      t_balanced();
      t_depth_clear();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule